// File: doc/BRIEF.md
# Calendar Clock with Full-Date Alarm

This block keeps wall-clock time and date in packed BCD: seconds, minutes, hours (24-hour), day of month, month, two-digit year (2000 to 2099) and a day-of-week count. It advances once for every `TICKS_PER_SEC` pulses of the slow `tick` input, which is a one-clock strobe at the 32768 Hz rate that is synchronous to `clk`. Month lengths and leap Februaries are handled in the carry chain. Software reaches every field through a byte-wide register port. A read returns the addressed byte in the same cycle. A write is applied at the next clock edge.

A six-field alarm is compared against the time after every advance. It fires only when all six fields are equal, because no field can be masked. A status byte reports a power-up flag, the alarm flag, the events of the last advance, the run state and a busy bit. The busy bit covers the final tick of each second, and software should avoid the time registers while it is set. An enable byte gates a one-clock timer pulse on each advance and a level alarm interrupt.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, reads return seconds, minutes, hours and year 0x00, day 0x01, month 0x01, weekday 0x00, control 0x00, interrupt enable 0x00 and status 0x80.
- R2: While control bit 0 is set, the time advances by one second on every `TICKS_PER_SEC`-th tick pulse. While that bit is clear, ticks change nothing. Status bit 1 reads back the run bit.
- R3: Seconds (offset 0x00) and minutes (0x04) count BCD 00 to 59 and wrap to 00. Hours (0x08) count 00 to 23 and wrap to 00. Each wrap carries into the next field.
- R4: Day (0x0C) wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February has 29 days when the BCD year is a multiple of 4 and 28 days otherwise. Month (0x10) wraps from 12 to 01 and year (0x14) from 99 to 00. Weekday (0x18) steps 0 to 6 at each change of day and wraps to 0.
- R5: Status bit 0 (busy) is 1 exactly while the clock runs and the current tick is the last tick of the second. It is 0 again after the advance.
- R6: A write to a time register replaces that field at the clock edge. A write to seconds restarts the sub-second tick count. If a write meets an advance in the same cycle, the written value wins for that field, while carries out of the lower fields still apply.
- R7: After each advance, status bits 5..2 describe that advance: bit 2 is always set, bit 3 is set if seconds wrapped, bit 4 if minutes wrapped, and bit 5 if hours wrapped. They hold until the next advance.
- R8: Status bit 6 (alarm) is set one clock after an advance that leaves all six fields equal to the alarm registers at 0x20, 0x24, 0x28, 0x2C, 0x30 and 0x34 (seconds through year). A mismatch in any single field prevents it.
- R9: In the status register at 0x44, writing 1 to bit 7 or bit 6 clears that bit, and writing 0 leaves it unchanged. Writes cannot change bits 5..0. Once bit 7 is cleared, it stays clear until reset.
- R10: The enable register at 0x48 stores only bit 3 (alarm) and bit 2 (timer). Other bits read 0. `irqAlarm` is high while status bit 6 and enable bit 3 are both set.
- R11: When enable bit 2 is set, `irqTimer` is high for exactly the one clock that follows each advance. Otherwise it stays low.
- R12: Control at 0x40 stores and reads back all 8 bits. The alarm registers read back as written. Misaligned or unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe at the slow oscillator rate |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| irqTimer | output | 1 | One-clock pulse after each advance when enabled |
| irqAlarm | output | 1 | Alarm interrupt level |

## Verification
Two functions can land on the same edge: a software write to the time fields and the rollover at the end of a second. The bench provokes this by sending the tick that completes a second in the very cycle that writes the seconds register while seconds read 59. The test passes only if seconds take the written value and minutes still advance by one. The bench also sweeps every month end over leap and non-leap years. It walks every hour boundary and a full minute, and computes each expected BCD value arithmetically.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NUM_TIME = 7;
  localparam int NUM_ALM  = 6;

  // field order inside the time array, also the register index order
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;
  localparam int F_WEEK = 6;

  // register word indices (byte offset / 4)
  localparam int IDX_ALM_BASE = 8;
  localparam logic [5:0] IDX_CTRL = 6'd16;
  localparam logic [5:0] IDX_STAT = 6'd17;
  localparam logic [5:0] IDX_IEN  = 6'd18;

  typedef struct packed {
    logic                step;
    logic [NUM_TIME-1:0] timeWr;
    logic [NUM_ALM-1:0]  alarmWr;
  } rtcStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] monthLast(input logic [7:0] mon, input logic [7:0] yr);
    logic [5:0] modSum;
    // 10 = 2 (mod 4), so tens*2 + ones keeps the residue of the year
    modSum = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
    case (mon)
      8'h02:                      return (modSum[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtcCtrl.sv
module rtcCtrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  input  logic       evtMin,
  input  logic       evtHour,
  input  logic       evtDay,
  input  logic       alarmMatch,
  output rtcStrobe_t strobe,
  output logic [7:0] ctrlReg,
  output logic [7:0] statusReg,
  output logic [7:0] ienReg,
  output logic       irqTimer,
  output logic       irqAlarm
);

  localparam int PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] LAST_TICK = PW'(TICKS_PER_SEC - 1);

  logic [5:0]    idx;
  logic          regWr;
  logic [PW-1:0] presc;
  logic          runBit;
  logic          busy;
  logic          stepQ;
  logic          powerUp;
  logic          alarmFlag;
  logic [3:0]    evtBits;
  logic [1:0]    ienBits;
  logic          statWr;

  assign idx    = addr[7:2];
  assign regWr  = wrEn && (addr[1:0] == 2'b00);
  assign statWr = regWr && (idx == IDX_STAT);
  assign runBit = ctrlReg[0];
  assign busy   = runBit && (presc == LAST_TICK);

  always_comb begin
    strobe.step = tick && busy;
    for (int i = 0; i < NUM_TIME; i++)
      strobe.timeWr[i] = regWr && (idx == 6'(i));
    for (int i = 0; i < NUM_ALM; i++)
      strobe.alarmWr[i] = regWr && (idx == 6'(IDX_ALM_BASE + i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else if (strobe.timeWr[F_SEC]) presc <= '0;
    else if (runBit && tick) presc <= (presc == LAST_TICK) ? '0 : presc + PW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      ienBits   <= '0;
      stepQ     <= 1'b0;
      irqTimer  <= 1'b0;
      evtBits   <= '0;
      powerUp   <= 1'b1;
      alarmFlag <= 1'b0;
    end else begin
      stepQ    <= strobe.step;
      irqTimer <= strobe.step && ienBits[0];
      if (regWr && idx == IDX_CTRL) ctrlReg <= wrData;
      if (regWr && idx == IDX_IEN)  ienBits <= wrData[3:2];
      if (strobe.step) evtBits <= {evtDay, evtHour, evtMin, 1'b1};
      if (statWr && wrData[7]) powerUp <= 1'b0;
      if (stepQ && alarmMatch)        alarmFlag <= 1'b1;
      else if (statWr && wrData[6])   alarmFlag <= 1'b0;
    end
  end

  assign statusReg = {powerUp, alarmFlag, evtBits, runBit, busy};
  assign ienReg    = {4'b0000, ienBits, 2'b00};
  assign irqAlarm  = alarmFlag && ienBits[1];

endmodule

// File: rtl/rtcDatapath.sv
module rtcDatapath
  import rtc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  rtcStrobe_t                    strobe,
  input  logic [7:0]                    wrData,
  output logic [NUM_TIME-1:0][7:0]      timeRegs,
  output logic [NUM_ALM-1:0][7:0]       alarmRegs,
  output logic                          evtMin,
  output logic                          evtHour,
  output logic                          evtDay,
  output logic                          alarmMatch
);

  logic [NUM_TIME-1:0]      adv;
  logic [NUM_TIME-1:0][7:0] incVal;
  logic                     secWrap, minWrap, hourWrap, dayWrap, monWrap;
  logic [7:0]               lastDay;

  always_comb begin
    lastDay  = monthLast(timeRegs[F_MON], timeRegs[F_YEAR]);
    secWrap  = strobe.step && (timeRegs[F_SEC]  == 8'h59);
    minWrap  = secWrap     && (timeRegs[F_MIN]  == 8'h59);
    hourWrap = minWrap     && (timeRegs[F_HOUR] == 8'h23);
    dayWrap  = hourWrap    && (timeRegs[F_DAY]  == lastDay);
    monWrap  = dayWrap     && (timeRegs[F_MON]  == 8'h12);

    adv[F_SEC]  = strobe.step;
    adv[F_MIN]  = secWrap;
    adv[F_HOUR] = minWrap;
    adv[F_DAY]  = hourWrap;
    adv[F_MON]  = dayWrap;
    adv[F_YEAR] = monWrap;
    adv[F_WEEK] = hourWrap;

    incVal[F_SEC]  = (timeRegs[F_SEC]  == 8'h59)   ? 8'h00 : bcdInc(timeRegs[F_SEC]);
    incVal[F_MIN]  = (timeRegs[F_MIN]  == 8'h59)   ? 8'h00 : bcdInc(timeRegs[F_MIN]);
    incVal[F_HOUR] = (timeRegs[F_HOUR] == 8'h23)   ? 8'h00 : bcdInc(timeRegs[F_HOUR]);
    incVal[F_DAY]  = (timeRegs[F_DAY]  == lastDay) ? 8'h01 : bcdInc(timeRegs[F_DAY]);
    incVal[F_MON]  = (timeRegs[F_MON]  == 8'h12)   ? 8'h01 : bcdInc(timeRegs[F_MON]);
    incVal[F_YEAR] = (timeRegs[F_YEAR] == 8'h99)   ? 8'h00 : bcdInc(timeRegs[F_YEAR]);
    incVal[F_WEEK] = (timeRegs[F_WEEK] == 8'h06)   ? 8'h00 : bcdInc(timeRegs[F_WEEK]);
  end

  assign evtMin  = secWrap;
  assign evtHour = minWrap;
  assign evtDay  = hourWrap;

  for (genvar i = 0; i < NUM_TIME; i++) begin : g_time
    localparam logic [7:0] RST_V = (i == F_DAY || i == F_MON) ? 8'h01 : 8'h00;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 timeRegs[i] <= RST_V;
      else if (strobe.timeWr[i]) timeRegs[i] <= wrData;
      else if (adv[i])           timeRegs[i] <= incVal[i];
    end
  end

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_alarm
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  alarmRegs[i] <= 8'h00;
      else if (strobe.alarmWr[i]) alarmRegs[i] <= wrData;
    end
  end

  always_comb begin
    alarmMatch = 1'b1;
    for (int i = 0; i < NUM_ALM; i++)
      if (alarmRegs[i] != timeRegs[i]) alarmMatch = 1'b0;
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [7:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irqTimer,
  output logic       irqAlarm
);

  rtcStrobe_t               strobe;
  logic [NUM_TIME-1:0][7:0] timeRegs;
  logic [NUM_ALM-1:0][7:0]  alarmRegs;
  logic [7:0]               ctrlReg, statusReg, ienReg;
  logic                     evtMin, evtHour, evtDay, alarmMatch;
  logic [5:0]               idx;

  rtcCtrl #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .evtMin(evtMin), .evtHour(evtHour), .evtDay(evtDay), .alarmMatch(alarmMatch),
    .strobe(strobe), .ctrlReg(ctrlReg), .statusReg(statusReg), .ienReg(ienReg),
    .irqTimer(irqTimer), .irqAlarm(irqAlarm)
  );

  rtcDatapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .timeRegs(timeRegs), .alarmRegs(alarmRegs),
    .evtMin(evtMin), .evtHour(evtHour), .evtDay(evtDay), .alarmMatch(alarmMatch)
  );

  assign idx = addr[7:2];

  always_comb begin
    rdData = 8'h00;
    if (addr[1:0] == 2'b00) begin
      for (int i = 0; i < NUM_TIME; i++)
        if (idx == 6'(i)) rdData = timeRegs[i];
      for (int i = 0; i < NUM_ALM; i++)
        if (idx == 6'(IDX_ALM_BASE + i)) rdData = alarmRegs[i];
      if (idx == IDX_CTRL) rdData = ctrlReg;
      if (idx == IDX_STAT) rdData = statusReg;
      if (idx == IDX_IEN)  rdData = ienReg;
    end
  end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input rtcStrobe_t strobe,
  input logic [7:0] ctrlReg,
  input logic [7:0] statusReg,
  input logic       irqTimer
);

  // R11
  timer_pulse_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqTimer |-> $past(strobe.step));

  // R11
  timer_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqTimer |=> !irqTimer);

  // R5
  busy_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> !statusReg[0]);

  // R8
  alarm_after_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[6]) |-> $past(strobe.step, 2));

  // R9
  power_up_stays_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusReg[7] |=> !statusReg[7]);

  // R2
  no_step_when_stopped_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[0] |-> !strobe.step);

endmodule

bind rtc_calendar rtc_calendar_chk i_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .ctrlReg(ctrlReg),
  .statusReg(statusReg), .irqTimer(irqTimer)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;

  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irqTimer, irqAlarm;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  rtc_calendar #(.TICKS_PER_SEC(TPS)) i_rtc_calendar (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqTimer(irqTimer), .irqAlarm(irqAlarm)
  );

  function automatic logic [7:0] toBcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int lastDayOf(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdData;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic setTime(input logic [7:0] y, mo, d, h, mi, s);
    wr(8'h14, y); wr(8'h10, mo); wr(8'h0C, d);
    wr(8'h08, h); wr(8'h04, mi); wr(8'h00, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    rd(8'h00, v); chk("R1 sec", v, 8'h00);
    rd(8'h04, v); chk("R1 min", v, 8'h00);
    rd(8'h08, v); chk("R1 hour", v, 8'h00);
    rd(8'h0C, v); chk("R1 day", v, 8'h01);
    rd(8'h10, v); chk("R1 month", v, 8'h01);
    rd(8'h14, v); chk("R1 year", v, 8'h00);
    rd(8'h18, v); chk("R1 week", v, 8'h00);
    rd(8'h40, v); chk("R1 ctrl", v, 8'h00);
    rd(8'h44, v); chk("R1 status", v, 8'h80);
    rd(8'h48, v); chk("R1 ien", v, 8'h00);

    // R12 storage and decode
    wr(8'h40, 8'hAB); rd(8'h40, v); chk("R12 ctrl readback", v, 8'hAB);
    wr(8'h2C, 8'h17); rd(8'h2C, v); chk("R12 alarm readback", v, 8'h17);
    rd(8'h1C, v); chk("R12 unmapped", v, 8'h00);
    rd(8'h2E, v); chk("R12 misaligned", v, 8'h00);
    rd(8'h4C, v); chk("R12 above map", v, 8'h00);

    // R2 stopped clock
    wr(8'h40, 8'h00); wr(8'h00, 8'h00);
    ticks(3 * TPS);
    rd(8'h00, v); chk("R2 frozen sec", v, 8'h00);
    rd(8'h44, v); chk("R2 run/busy clear", v & 8'h03, 8'h00);
    wr(8'h40, 8'h01);
    rd(8'h44, v); chk("R2 run bit", v & 8'h02, 8'h02);

    // R5 busy on last tick
    wr(8'h00, 8'h00);
    ticks(TPS - 1);
    rd(8'h44, v); chk("R5 busy high", v & 8'h01, 8'h01);
    rd(8'h00, v); chk("R5 no advance yet", v, 8'h00);
    ticks(1);
    rd(8'h44, v); chk("R5 busy low", v & 8'h01, 8'h00);
    rd(8'h00, v); chk("R2 one second", v, 8'h01);

    // R6 seconds write restarts prescaler
    ticks(2);
    wr(8'h00, 8'h20);
    ticks(TPS - 1);
    rd(8'h00, v); chk("R6 restart hold", v, 8'h20);
    ticks(1);
    rd(8'h00, v); chk("R6 restart step", v, 8'h21);

    // R6 write and rollover on the same edge
    setTime(8'h00, 8'h01, 8'h01, 8'h00, 8'h10, 8'h59);
    ticks(TPS - 1);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; addr = 8'h00; wrData = 8'h30;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    rd(8'h00, v); chk("R6 collision sec", v, 8'h30);
    rd(8'h04, v); chk("R6 collision carry", v, 8'h11);

    // R3 one minute plus one second, counted arithmetically
    setTime(8'h00, 8'h01, 8'h01, 8'h05, 8'h00, 8'h00);
    for (int i = 1; i <= 61; i++) begin
      ticks(TPS);
      rd(8'h00, v); chk("R3 sec sweep", v, toBcd(i % 60));
      rd(8'h04, v); chk("R3 min sweep", v, toBcd(i / 60));
    end

    // R3 every hour boundary
    for (int h = 0; h < 24; h++) begin
      setTime(8'h00, 8'h01, 8'h10, toBcd(h), 8'h59, 8'h59);
      ticks(TPS);
      rd(8'h08, v); chk("R3 hour wrap", v, toBcd((h + 1) % 24));
      rd(8'h04, v); chk("R3 min zero", v, 8'h00);
      rd(8'h0C, v); chk("R3 day carry", v, (h == 23) ? 8'h11 : 8'h10);
    end

    // R4 month ends over leap and non-leap years
    for (int yi = 0; yi < 6; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        int y, ld;
        y  = (yi < 5) ? yi : 99;
        ld = lastDayOf(m, y);
        setTime(toBcd(y), toBcd(m), toBcd(ld - 1), 8'h23, 8'h59, 8'h59);
        ticks(TPS);
        rd(8'h0C, v); chk("R4 day before end", v, toBcd(ld));
        rd(8'h10, v); chk("R4 month held", v, toBcd(m));
        setTime(toBcd(y), toBcd(m), toBcd(ld), 8'h23, 8'h59, 8'h59);
        ticks(TPS);
        rd(8'h0C, v); chk("R4 day wrap", v, 8'h01);
        rd(8'h10, v); chk("R4 month step", v, toBcd(m % 12 + 1));
        rd(8'h14, v); chk("R4 year", v, (m == 12) ? toBcd((y + 1) % 100) : toBcd(y));
      end
    end

    // R4 weekday
    wr(8'h18, 8'h06);
    setTime(8'h05, 8'h03, 8'h03, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    rd(8'h18, v); chk("R4 weekday wrap", v, 8'h00);
    ticks(TPS);
    rd(8'h18, v); chk("R4 weekday held", v, 8'h00);
    setTime(8'h05, 8'h03, 8'h04, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    rd(8'h18, v); chk("R4 weekday step", v, 8'h01);

    // R7 event bits
    setTime(8'h05, 8'h03, 8'h05, 8'h23, 8'h59, 8'h59);
    ticks(TPS);
    rd(8'h44, v); chk("R7 day event", v & 8'h3C, 8'h3C);
    ticks(TPS);
    rd(8'h44, v); chk("R7 second event", v & 8'h3C, 8'h04);
    setTime(8'h05, 8'h03, 8'h05, 8'h12, 8'h34, 8'h59);
    ticks(TPS);
    rd(8'h44, v); chk("R7 minute event", v & 8'h3C, 8'h0C);
    setTime(8'h05, 8'h03, 8'h05, 8'h12, 8'h59, 8'h59);
    ticks(TPS);
    rd(8'h44, v); chk("R7 hour event", v & 8'h3C, 8'h1C);

    // R11 timer pulse
    wr(8'h48, 8'h04);
    ticks(TPS - 1);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    #1 chk("R11 pulse high", {7'b0, irqTimer}, 8'h01);
    @(negedge clk);
    #1 chk("R11 pulse one clock", {7'b0, irqTimer}, 8'h00);
    wr(8'h48, 8'h00);
    ticks(TPS - 1);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    #1 chk("R11 disabled", {7'b0, irqTimer}, 8'h00);

    // R8 full-date alarm
    wr(8'h48, 8'h08);
    wr(8'h20, 8'h59); wr(8'h24, 8'h59); wr(8'h28, 8'h23);
    wr(8'h2C, 8'h29); wr(8'h30, 8'h02); wr(8'h34, 8'h24);
    setTime(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h57);
    ticks(TPS);
    rd(8'h44, v); chk("R8 not yet", v & 8'h40, 8'h00);
    chk("R8 irq low", {7'b0, irqAlarm}, 8'h00);
    ticks(TPS);
    rd(8'h44, v); chk("R8 alarm set", v & 8'h40, 8'h40);
    chk("R8 irq high", {7'b0, irqAlarm}, 8'h01);

    // R10 enable gating
    wr(8'h48, 8'h00);
    #1 chk("R10 irq gated", {7'b0, irqAlarm}, 8'h00);
    wr(8'h48, 8'hFF);
    rd(8'h48, v); chk("R10 ien bits", v, 8'h0C);
    chk("R10 irq restored", {7'b0, irqAlarm}, 8'h01);

    // R9 write-one-to-clear
    rd(8'h44, v2);
    wr(8'h44, 8'h3F);
    rd(8'h44, v); chk("R9 low bits read-only", v & 8'hFC, v2 & 8'hFC);
    wr(8'h44, 8'h00);
    rd(8'h44, v); chk("R9 zero no effect", v & 8'hC0, 8'hC0);
    wr(8'h44, 8'h40);
    rd(8'h44, v); chk("R9 alarm cleared", v & 8'hC0, 8'h80);
    chk("R9 irq dropped", {7'b0, irqAlarm}, 8'h00);
    wr(8'h44, 8'h80);
    rd(8'h44, v); chk("R9 power-up cleared", v & 8'hC0, 8'h00);

    // R8 no masking: only the year differs
    wr(8'h34, 8'h25);
    setTime(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h58);
    ticks(TPS);
    rd(8'h44, v); chk("R8 year mismatch", v & 8'h40, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule